// File: doc/BRIEF.md
# Integer ALU with Operation Decoder

This block is the arithmetic unit of a simple multi-cycle processor together with the small decoder that drives it. The main controller supplies a 2-bit class code. That code either forces an addition (used for address and program-counter arithmetic) or forces a subtraction (used for equality tests). With the third value, it hands the choice to the 6-bit function field of an arithmetic instruction. The decoder turns this pair into a fixed 3-bit operation code. The datapath then applies that operation to two W-bit operands.

The block is purely combinational. Besides the result, it reports a zero flag, which the controller uses for conditional branches. It also reports a signed overflow flag, which is only meaningful for addition and subtraction. The decoded 3-bit operation code is brought out as a port so that the encoding can be observed directly.

Top module: `alu_unit`

## Requirements
- R1: The class code drives the decoded operation select `op_sel` as follows: class 00 gives the add code 3'b010 and class 01 gives the subtract code 3'b110, whatever the function field holds.
- R2: With class 10, the function field picks the operation: 6'b100000 gives add (3'b010), 6'b100010 gives subtract (3'b110), 6'b100100 gives AND (3'b000), 6'b100101 gives OR (3'b001) and 6'b101010 gives set-on-less-than (3'b111).
- R3: Class 11, or class 10 with any function code not listed in R2, decodes to add (3'b010).
- R4: AND and OR produce the bitwise AND and bitwise OR of the two operands.
- R5: Add and subtract produce a + b and a - b modulo 2^W.
- R6: Set-on-less-than compares the operands as signed two's-complement numbers. It returns 1 in bit 0 when a < b and 0 otherwise, and all upper bits are always zero.
- R7: `zero` is 1 exactly when every bit of `result` is 0.
- R8: `overflow` is 1 only for add and subtract, and only when the signed mathematical result lies outside the range -2^(W-1) to 2^(W-1)-1. It is 0 for AND, OR and set-on-less-than.
- R9: Outside class 10 the function field has no effect on `op_sel`, `result`, `zero` or `overflow`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aluop | input | 2 | Operation class from the main controller |
| funct | input | 6 | Function field of the instruction |
| a | input | W | First operand |
| b | input | W | Second operand |
| result | output | W | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| op_sel | output | 3 | Decoded operation code |

## Verification
A 4-bit instance is swept over every operand pair, for every class code and for each listed function code plus one unknown code. This separates signed from unsigned comparison, and add-overflow from subtract-overflow, at every sign combination. Outside class 10 the sweep repeats with two different function fields, so a leak of the function field into the decode shows up as a changed result. A 32-bit instance is driven with the extreme values (largest positive, most negative, -1, zero and equal pairs) through all function codes. This exposes carry and overflow mistakes that only appear at full width, including a zero result that comes with an overflow.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FIELD = 2'b10,
    CLS_RSVD  = 2'b11
  } alu_cls_e;

  localparam int FN_W = 6;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  function automatic alu_op_e field_to_op(input logic [FN_W-1:0] fn);
    case (fn)
      FN_ADD:  return OP_ADD;
      FN_SUB:  return OP_SUB;
      FN_AND:  return OP_AND;
      FN_OR:   return OP_OR;
      FN_SLT:  return OP_SLT;
      default: return OP_ADD;
    endcase
  endfunction

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [1:0]      cls,
  input  logic [FN_W-1:0] fn,
  output alu_op_e         op
);

  alu_op_e field_op;

  always_comb field_op = field_to_op(fn);

  always_comb begin
    case (alu_cls_e'(cls))
      CLS_ADD:   op = OP_ADD;
      CLS_SUB:   op = OP_SUB;
      CLS_FIELD: op = field_op;
      default:   op = OP_ADD;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   result,
  output logic           arith_ovf,
  output logic           ovf_out
);

  localparam int MSB = W - 1;

  // Overflow when both adder inputs share a sign that the sum does not.
  function automatic logic sign_clash(input logic sa, input logic sb, input logic ss);
    return (sa == sb) && (ss != sa);
  endfunction

  function automatic logic [W-1:0] lsb_flag(input logic bit_in);
    logic [W-1:0] v;
    v = '0;
    v[0] = bit_in;
    return v;
  endfunction

  logic          inv_b;
  logic [W-1:0]  b_eff;
  logic [W-1:0]  sum;
  logic          less;

  always_comb begin
    inv_b     = (op == OP_SUB) || (op == OP_SLT);
    b_eff     = inv_b ? ~b : b;
    sum       = a + b_eff + W'(inv_b);
    arith_ovf = sign_clash(a[MSB], b_eff[MSB], sum[MSB]);
    less      = sum[MSB] ^ arith_ovf;
  end

  always_comb begin
    case (op)
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_SLT:  result = lsb_flag(less);
      default: result = sum;
    endcase
    ovf_out = arith_ovf && ((op == OP_ADD) || (op == OP_SUB));
  end

endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  output logic         all_zero
);

  always_comb all_zero = (value == '0);

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   aluop,
  input  logic [5:0]   funct,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         overflow,
  output logic [2:0]   op_sel
);

  alu_op_e       dec_op;
  logic [W-1:0]  dp_result;
  logic          raw_ovf;
  logic          dp_ovf;
  logic          dp_zero;

  alu_op_decode u_dec (
    .cls (aluop),
    .fn  (funct),
    .op  (dec_op)
  );

  alu_datapath #(.W(W)) u_dp (
    .op        (dec_op),
    .a         (a),
    .b         (b),
    .result    (dp_result),
    .arith_ovf (raw_ovf),
    .ovf_out   (dp_ovf)
  );

  alu_flag_gen #(.W(W)) u_flag (
    .value    (dp_result),
    .all_zero (dp_zero)
  );

  assign result   = dp_result;
  assign zero     = dp_zero;
  assign overflow = dp_ovf;
  assign op_sel   = dec_op;

endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
  parameter int W = 32
) (
  input logic [1:0]   aluop,
  input logic [5:0]   funct,
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         overflow,
  input logic [2:0]   op_sel,
  input logic         raw_ovf
);

  always_comb begin
    if (aluop == 2'b00) AST_CLS_ADD: assert (op_sel == 3'b010); // R1
    if (aluop == 2'b01) AST_CLS_SUB: assert (op_sel == 3'b110); // R1
    if (aluop == 2'b11) AST_CLS_RSVD: assert (op_sel == 3'b010); // R3
    if (aluop == 2'b10 && funct == 6'b101010) AST_FN_SLT: assert (op_sel == 3'b111); // R2
    if (op_sel == 3'b111) AST_SLT_UPPER: assert (result[W-1:1] == '0); // R6
    if (op_sel == 3'b111 && a == b) AST_SLT_EQUAL: assert (result == '0); // R6
    if (zero) AST_ZERO_MEANS_CLEAR: assert (result == '0); // R7
    if (overflow) AST_OVF_ARITH_ONLY: assert ((op_sel == 3'b010 || op_sel == 3'b110) && raw_ovf); // R8
  end

endmodule

bind alu_unit alu_unit_chk #(.W(W)) i_chk (
  .aluop    (aluop),
  .funct    (funct),
  .a        (a),
  .b        (b),
  .result   (result),
  .zero     (zero),
  .overflow (overflow),
  .op_sel   (op_sel),
  .raw_ovf  (raw_ovf)
);

// File: tb/test_alu_unit.sv
`timescale 1ns/1ps
module test_alu_unit;

  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done = 1'b0;
  int   checks = 0;
  int   failures = 0;

  always #2 clk = ~clk;

  // full-width instance
  logic [1:0]  aluop;
  logic [5:0]  funct;
  logic [31:0] a, b, result;
  logic        zero, overflow;
  logic [2:0]  op_sel;

  alu_unit i_alu_unit (
    .aluop(aluop), .funct(funct), .a(a), .b(b),
    .result(result), .zero(zero), .overflow(overflow), .op_sel(op_sel)
  );

  // small instance for exhaustive sweeps
  logic [1:0]    s_aluop;
  logic [5:0]    s_funct;
  logic [SW-1:0] s_a, s_b, s_result;
  logic          s_zero, s_overflow;
  logic [2:0]    s_op_sel;

  alu_unit #(.W(SW)) i_alu_small (
    .aluop(s_aluop), .funct(s_funct), .a(s_a), .b(s_b),
    .result(s_result), .zero(s_zero), .overflow(s_overflow), .op_sel(s_op_sel)
  );

  function automatic logic [2:0] exp_op(input logic [1:0] cls, input logic [5:0] fn);
    if (cls == 2'b01) return 3'b110;
    if (cls != 2'b10) return 3'b010;
    case (fn)
      6'b100010: return 3'b110;
      6'b100100: return 3'b000;
      6'b100101: return 3'b001;
      6'b101010: return 3'b111;
      default:   return 3'b010;
    endcase
  endfunction

  task automatic model(input int w, input logic [2:0] op,
                       input logic [63:0] ua, input logic [63:0] ub,
                       output logic [63:0] res, output logic z, output logic ov);
    longint m, sa, sb, full, hi, lo;
    m  = (longint'(1) <<< w) - 1;
    sa = longint'(ua) & m;
    sb = longint'(ub) & m;
    if (ua[w-1]) sa = sa - (longint'(1) <<< w);
    if (ub[w-1]) sb = sb - (longint'(1) <<< w);
    hi = (longint'(1) <<< (w-1)) - 1;
    lo = -(longint'(1) <<< (w-1));
    ov = 1'b0;
    full = 0;
    case (op)
      3'b000: full = sa & sb;
      3'b001: full = sa | sb;
      3'b110: begin full = sa - sb; ov = (full > hi) || (full < lo); end
      3'b111: full = (sa < sb) ? 1 : 0;
      default: begin full = sa + sb; ov = (full > hi) || (full < lo); end
    endcase
    res = 64'(full & m);
    z   = (res == 64'd0);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic string res_tag(input logic [2:0] op);
    case (op)
      3'b000, 3'b001: return "R4";
      3'b111:         return "R6";
      default:        return "R5";
    endcase
  endfunction

  task automatic judge(input int w, input logic [1:0] cls, input logic [5:0] fn,
                       input logic [63:0] ua, input logic [63:0] ub,
                       input logic [63:0] r_act, input logic z_act,
                       input logic o_act, input logic [2:0] op_act);
    logic [2:0]  eop;
    logic [63:0] er;
    logic        ez, eo;
    string       otag;
    eop = exp_op(cls, fn);
    model(w, eop, ua, ub, er, ez, eo);
    if (cls == 2'b10) otag = (eop == 3'b010 && fn != 6'b100000) ? "R3" : "R2";
    else if (cls == 2'b11) otag = "R3";
    else otag = "R1";
    if (cls != 2'b10 && fn != 6'b000000) otag = "R9";
    check(otag, "op_sel", 64'(op_act), 64'(eop));
    check(res_tag(eop), "result", r_act, er);
    check("R7", "zero", 64'(z_act), 64'(ez));
    check("R8", "overflow", 64'(o_act), 64'(eo));
  endtask

  logic [5:0] fn_list [6] = '{6'b100000, 6'b100010, 6'b100100,
                               6'b100101, 6'b101010, 6'b000111};
  logic [31:0] corner [8] = '{32'h7fffffff, 32'h80000000, 32'hffffffff,
                              32'h00000000, 32'h00000001, 32'h55555555,
                              32'haaaaaaaa, 32'h80000001};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    aluop = 2'b00; funct = 6'b0; a = '0; b = '0;
    s_aluop = 2'b00; s_funct = 6'b0; s_a = '0; s_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // idle inputs: zero result, zero flag set (R7)
    check("R7", "idle zero", 64'(zero), 64'd1);
    check("R5", "idle result", 64'(result), 64'd0);

    // exhaustive small sweep
    for (int cls = 0; cls < 4; cls++) begin
      for (int fi = 0; fi < 6; fi++) begin
        logic [5:0] fn;
        if (cls == 2) fn = fn_list[fi];
        else if (fi > 1) continue;
        else fn = (fi == 0) ? 6'b000000 : 6'b100100;
        for (int ia = 0; ia < (1 << SW); ia++) begin
          for (int ib = 0; ib < (1 << SW); ib++) begin
            @(negedge clk);
            s_aluop = 2'(cls); s_funct = fn; s_a = SW'(ia); s_b = SW'(ib);
            #1;
            judge(SW, 2'(cls), fn, 64'(s_a), 64'(s_b), 64'(s_result),
                  s_zero, s_overflow, s_op_sel);
          end
        end
      end
    end

    // full-width corners through all field codes and forced classes
    for (int cls = 0; cls < 4; cls++) begin
      for (int fi = 0; fi < 6; fi++) begin
        for (int ia = 0; ia < 8; ia++) begin
          for (int ib = 0; ib < 8; ib++) begin
            @(negedge clk);
            aluop = 2'(cls); funct = fn_list[fi]; a = corner[ia]; b = corner[ib];
            #1;
            judge(32, 2'(cls), fn_list[fi], 64'(a), 64'(b), 64'(result),
                  zero, overflow, op_sel);
          end
        end
      end
    end

    // directed: add of two most-negative values wraps to zero with overflow (R8)
    @(negedge clk);
    aluop = 2'b00; funct = 6'b0; a = 32'h80000000; b = 32'h80000000;
    #1;
    check("R8", "wrap overflow", 64'(overflow), 64'd1);
    check("R7", "wrap zero", 64'(zero), 64'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule